// File: doc/BRIEF.md
# NAND Flash Register Front-End

This block sits between a simple 32-bit processor register bus and the raw pins of an 8-bit NAND flash device. Each host write to the command register becomes one command-latch bus cycle and each write to the address register becomes one address-latch cycle. A data-register write sends one byte with a write strobe. A data-register read performs one read strobe and returns the sampled byte. Software drives the whole flash protocol itself, one byte at a time. The block only shapes the strobes and latch enables with correct timing.

A control register holds the write-protect, chip-deselect, bus-width and page-size settings, plus a self-clearing soft reset. A global register enables the flash function and can reinitialise the interface. A status register shows the device ready/busy line after a two-stage synchroniser. Bit 31 of an address write marks the last address byte of a phase. The address-latch enable therefore stays high across a multi-byte address and drops only after the marked byte. While a flash bus cycle is in progress, any further host access is held off with a wait signal.

Top module: `nand_bus_front`

## Requirements
- R1: After reset the pins are idle: `cmdLatch`=0, `addrLatch`=0, `wrStrobeN`=1, `rdStrobeN`=1, `chipEnN`=1, `wrProtN`=0 and `hostWait`=0. The global register (offset 0x00) reads 0 and the control register (offset 0xA0) reads 0x03000000.
- R2: A write to offset 0xB0 produces one write-strobe pulse. During this pulse `cmdLatch`=1, `addrLatch`=0 and `ioOe`=1, and `ioOut` carries bits 7:0 of the written word. `wrStrobeN` stays low for exactly PULSE_CLKS clocks. For one further clock after it rises, `cmdLatch` and `ioOut` hold their values.
- R3: A write to offset 0xB4 produces one write-strobe pulse with `addrLatch`=1, `cmdLatch`=0 and `ioOut` equal to bits 7:0. If bit 31 of the written word is 0, `addrLatch` stays 1 after the cycle. If bit 31 is 1, `addrLatch` falls when the cycle ends.
- R4: A write to offset 0xB8 produces one write-strobe pulse with both latch enables low, `ioOe`=1 and `ioOut` equal to bits 7:0. The write and read strobes are never low together.
- R5: A read of offset 0xB8 produces exactly one read-strobe pulse of PULSE_CLKS clocks and no write strobe. The read returns the byte present on `ioIn` during the strobe in bits 7:0, with bits 31:8 equal to 0.
- R6: While a bus cycle is running, any host access sees `hostWait`=1. After an accepted command, address or data write, the wait lasts PULSE_CLKS+1 clocks.
- R7: Bit 18 of the status register (offset 0xAC) shows `readyBusy` through two flip-flops. The host can read it one clock after the second clock edge that follows a change.
- R8: In the control register, bits 3, 4, 24 and 25 are stored and read back. Bits 0, 1, 2 and 5 always read 0. `wrProtN` is the inverse of bit 24.
- R9: `chipEnN` is 0 only when global bit 3 is 1 and control bit 25 is 0.
- R10: Writing control bit 0 as 1 ends an open address phase, so `addrLatch` goes to 0.
- R11: Writing global bit 0 as 1 restores the control register to 0x03000000 and ends an open address phase. Global bit 3 takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostSel | input | 1 | Host access request, held until accepted |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Register byte offset |
| hostWdata | input | 32 | Write data |
| hostRdata | output | 32 | Read data, valid when `hostWait` is low |
| hostWait | output | 1 | Stall; the access completes on an edge where it is low |
| cmdLatch | output | 1 | Command latch enable |
| addrLatch | output | 1 | Address latch enable |
| wrStrobeN | output | 1 | Write strobe, active low |
| rdStrobeN | output | 1 | Read strobe, active low |
| chipEnN | output | 1 | Chip enable, active low |
| wrProtN | output | 1 | Write protect, active low |
| ioOut | output | 8 | Byte driven to the device |
| ioOe | output | 1 | Output enable for `ioOut` |
| ioIn | input | 8 | Byte from the device |
| readyBusy | input | 1 | Device ready (1) / busy (0) |

## Verification
Each flash cycle starts on the edge that accepts the host write. The strobe then stays low for PULSE_CLKS clocks and the hold phase lasts one more clock. The bench therefore reads the latch enables and the byte at the first falling edge where the strobe is seen high again, and it measures the strobe width in falling-edge samples. Wait lengths are counted from the falling edge after acceptance. Status bit 18 is sampled at the falling edges after the first and second rising edges that follow a change on `readyBusy`. Register and latch effects of control writes are checked at the first falling edge after the accepting edge.

// File: rtl/nand_front_pkg.sv
package nand_front_pkg;
  localparam int HOST_W = 32;
  localparam int IO_W   = 8;

  localparam logic [7:0] OFS_GLOBAL = 8'h00;
  localparam logic [7:0] OFS_CTRL   = 8'hA0;
  localparam logic [7:0] OFS_STAT   = 8'hAC;
  localparam logic [7:0] OFS_CMD    = 8'hB0;
  localparam logic [7:0] OFS_ADDR   = 8'hB4;
  localparam logic [7:0] OFS_DATA   = 8'hB8;

  localparam int BIT_RST     = 0;
  localparam int BIT_ENABLE  = 3;
  localparam int BIT_PAGESZ  = 3;
  localparam int BIT_BUSW    = 4;
  localparam int BIT_WPROT   = 24;
  localparam int BIT_DESEL   = 25;
  localparam int BIT_READY   = 18;
  localparam int BIT_LASTADR = 31;

  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_WR, OP_RD} busOp_e;

  typedef struct packed {
    logic   busy;
    busOp_e op;
    logic   weLow;
    logic   reLow;
    logic   capture;
    logic   finish;
  } cycStrb_t;
endpackage

// File: rtl/nand_front_seq.sv
module nand_front_seq
  import nand_front_pkg::*;
#(
  parameter int PULSE_CLKS = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  busOp_e   startOp,
  output cycStrb_t strb
);
  localparam int CNT_W = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_HOLD} seqState_e;

  seqState_e        state;
  logic [CNT_W-1:0] cnt;
  busOp_e           op;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      op    <= OP_CMD;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_STROBE;
          op    <= startOp;
          cnt   <= CNT_W'(PULSE_CLKS - 1);
        end
        ST_STROBE: begin
          if (cnt == '0) state <= ST_HOLD;
          else cnt <= cnt - 1'b1;
        end
        ST_HOLD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.busy    = (state != ST_IDLE);
    strb.op      = op;
    strb.weLow   = (state == ST_STROBE) && (op != OP_RD);
    strb.reLow   = (state == ST_STROBE) && (op == OP_RD);
    strb.capture = (state == ST_STROBE) && (op == OP_RD) && (cnt == '0);
    strb.finish  = (state == ST_HOLD);
  end

  // R6: the datapath launches a cycle only while the sequencer is idle
  assert_start_when_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    start |-> (state == ST_IDLE));

  // R4: write and read strobes never overlap
  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.weLow && strb.reLow));
endmodule

// File: rtl/nand_front_dp.sv
module nand_front_dp
  import nand_front_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [HOST_W-1:0] hostWdata,
  output logic [HOST_W-1:0] hostRdata,
  output logic              hostWait,
  input  cycStrb_t          strb,
  output logic              start,
  output busOp_e            startOp,
  output logic              cmdLatch,
  output logic              addrLatch,
  output logic              wrStrobeN,
  output logic              rdStrobeN,
  output logic              chipEnN,
  output logic              wrProtN,
  output logic [IO_W-1:0]   ioOut,
  output logic              ioOe,
  input  logic [IO_W-1:0]   ioIn,
  input  logic              readyBusy
);
  localparam logic [HOST_W-1:0] CTRL_RESET = HOST_W'(1) << BIT_WPROT | HOST_W'(1) << BIT_DESEL;

  logic isGlobal, isCtrl, isStat, isCmd, isAddr, isData;
  logic accept, wrAccept, rdPending;
  logic glbEnable, pageSz, busWide, wProt, deSel;
  logic aleHold, lastFlag, rdReady;
  logic [IO_W-1:0] rdHold;
  logic [SYNC_STAGES-1:0] rdySync;

  assign isGlobal = (hostAddr == ADDR_W'(OFS_GLOBAL));
  assign isCtrl   = (hostAddr == ADDR_W'(OFS_CTRL));
  assign isStat   = (hostAddr == ADDR_W'(OFS_STAT));
  assign isCmd    = (hostAddr == ADDR_W'(OFS_CMD));
  assign isAddr   = (hostAddr == ADDR_W'(OFS_ADDR));
  assign isData   = (hostAddr == ADDR_W'(OFS_DATA));

  assign rdPending = !hostWr && isData && !rdReady;
  assign hostWait  = hostSel && (strb.busy || rdPending);
  assign accept    = hostSel && !hostWait;
  assign wrAccept  = accept && hostWr;
  assign start     = hostSel && !strb.busy &&
                     ((hostWr && (isCmd || isAddr || isData)) || rdPending);

  always_comb begin
    if (!hostWr)     startOp = OP_RD;
    else if (isCmd)  startOp = OP_CMD;
    else if (isAddr) startOp = OP_ADDR;
    else             startOp = OP_WR;
  end

  // ready/busy synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdySync <= '0;
    else       rdySync <= {rdySync[SYNC_STAGES-2:0], readyBusy};
  end

  // register file and phase state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      glbEnable <= 1'b0;
      pageSz    <= CTRL_RESET[BIT_PAGESZ];
      busWide   <= CTRL_RESET[BIT_BUSW];
      wProt     <= CTRL_RESET[BIT_WPROT];
      deSel     <= CTRL_RESET[BIT_DESEL];
      aleHold   <= 1'b0;
      lastFlag  <= 1'b0;
      rdReady   <= 1'b0;
      rdHold    <= '0;
      ioOut     <= '0;
    end else begin
      if (start) begin
        aleHold <= (startOp == OP_ADDR);
        if (hostWr) begin
          ioOut    <= hostWdata[IO_W-1:0];
          lastFlag <= hostWdata[BIT_LASTADR];
        end
      end
      if (strb.finish && strb.op == OP_ADDR && lastFlag) aleHold <= 1'b0;
      if (strb.capture) rdHold <= ioIn;
      if (strb.finish && strb.op == OP_RD) rdReady <= 1'b1;
      if (accept && !hostWr && isData) rdReady <= 1'b0;

      if (wrAccept && isCtrl) begin
        pageSz  <= hostWdata[BIT_PAGESZ];
        busWide <= hostWdata[BIT_BUSW];
        wProt   <= hostWdata[BIT_WPROT];
        deSel   <= hostWdata[BIT_DESEL];
        if (hostWdata[BIT_RST]) begin
          aleHold <= 1'b0;
          rdReady <= 1'b0;
        end
      end
      if (wrAccept && isGlobal) begin
        glbEnable <= hostWdata[BIT_ENABLE];
        if (hostWdata[BIT_RST]) begin
          pageSz  <= CTRL_RESET[BIT_PAGESZ];
          busWide <= CTRL_RESET[BIT_BUSW];
          wProt   <= CTRL_RESET[BIT_WPROT];
          deSel   <= CTRL_RESET[BIT_DESEL];
          aleHold <= 1'b0;
          rdReady <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    hostRdata = '0;
    if (isGlobal) hostRdata[BIT_ENABLE] = glbEnable;
    if (isCtrl) begin
      hostRdata[BIT_PAGESZ] = pageSz;
      hostRdata[BIT_BUSW]   = busWide;
      hostRdata[BIT_WPROT]  = wProt;
      hostRdata[BIT_DESEL]  = deSel;
    end
    if (isStat) hostRdata[BIT_READY] = rdySync[SYNC_STAGES-1];
    if (isData) hostRdata[IO_W-1:0]  = rdHold;
  end

  assign cmdLatch  = strb.busy && (strb.op == OP_CMD);
  assign addrLatch = aleHold;
  assign wrStrobeN = !strb.weLow;
  assign rdStrobeN = !strb.reLow;
  assign ioOe      = strb.busy && (strb.op != OP_RD);
  assign chipEnN   = !(glbEnable && !deSel);
  assign wrProtN   = !wProt;

  // R3: the two latch enables never overlap
  assert_latch_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdLatch && addrLatch));

  // R3: a marked final address byte closes the address phase
  assert_ale_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && strb.op == OP_ADDR && lastFlag) |=> !addrLatch);

  // R4: the byte bus is driven whenever the write strobe is low
  assert_oe_with_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobeN |-> ioOe);

  // R6: a running cycle stalls any host access
  assert_wait_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostSel && strb.busy) |-> hostWait);

  // R5: completed data reads carry only a byte
  assert_read_upper_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !hostWr && isData) |-> (hostRdata[HOST_W-1:IO_W] == '0));
endmodule

// File: rtl/nand_bus_front.sv
module nand_bus_front
  import nand_front_pkg::*;
#(
  parameter int PULSE_CLKS  = 2,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              hostWait,
  output logic              cmdLatch,
  output logic              addrLatch,
  output logic              wrStrobeN,
  output logic              rdStrobeN,
  output logic              chipEnN,
  output logic              wrProtN,
  output logic [7:0]        ioOut,
  output logic              ioOe,
  input  logic [7:0]        ioIn,
  input  logic              readyBusy
);
  cycStrb_t strb;
  logic     start;
  busOp_e   startOp;

  nand_front_seq #(.PULSE_CLKS(PULSE_CLKS)) u_seq (
    .clk(clk), .rstN(rstN), .start(start), .startOp(startOp), .strb(strb)
  );

  nand_front_dp #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN),
    .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostWait(hostWait),
    .strb(strb), .start(start), .startOp(startOp),
    .cmdLatch(cmdLatch), .addrLatch(addrLatch),
    .wrStrobeN(wrStrobeN), .rdStrobeN(rdStrobeN),
    .chipEnN(chipEnN), .wrProtN(wrProtN),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn), .readyBusy(readyBusy)
  );
endmodule

// File: tb/nand_bus_front_bench.sv
module nand_bus_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 2;

  logic clk = 0, rstN = 0;
  logic hostSel = 0, hostWr = 0;
  logic [7:0] hostAddr = 0;
  logic [31:0] hostWdata = 0;
  logic [31:0] hostRdata;
  logic hostWait, cmdLatch, addrLatch, wrStrobeN, rdStrobeN, chipEnN, wrProtN, ioOe;
  logic [7:0] ioOut;
  logic [7:0] ioIn = 0;
  logic readyBusy = 0;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_bus_front #(.PULSE_CLKS(PULSE)) u_nand_bus_front (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostWait(hostWait),
    .cmdLatch(cmdLatch), .addrLatch(addrLatch), .wrStrobeN(wrStrobeN),
    .rdStrobeN(rdStrobeN), .chipEnN(chipEnN), .wrProtN(wrProtN),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn), .readyBusy(readyBusy)
  );

  // strobe monitor, sampled on falling edges
  logic prevWe = 1, prevRe = 1;
  int weRun = 0, weLen = 0, weRises = 0, reRun = 0, reLen = 0, reCount = 0;
  logic lastCle = 0, lastAle = 0, lastOe = 0;
  logic [7:0] lastIo = 0;
  always @(negedge clk) begin
    if (!wrStrobeN) weRun++;
    else if (!prevWe) begin
      weLen = weRun; weRun = 0; weRises++;
      lastCle = cmdLatch; lastAle = addrLatch; lastIo = ioOut; lastOe = ioOe;
    end
    if (!rdStrobeN) reRun++;
    else if (!prevRe) begin reLen = reRun; reRun = 0; reCount++; end
    prevWe = wrStrobeN; prevRe = rdStrobeN;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // entered at a falling edge; leaves at a falling edge
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, output int waits);
    hostSel = 1; hostWr = 1; hostAddr = a; hostWdata = d; #1;
    waits = 0;
    while (hostWait) begin waits++; @(negedge clk); end
    @(negedge clk);
    hostSel = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    hostSel = 1; hostWr = 0; hostAddr = a; #1;
    while (hostWait) @(negedge clk);
    d = hostRdata;
    @(negedge clk);
    hostSel = 0;
  endtask

  typedef struct packed {
    logic [7:0]  off;
    logic [31:0] wdata;
    logic [7:0]  expByte;
    logic        expCle;
    logic        expAle;
    logic        expAleAfter;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{8'hB0, 32'h1234_5680, 8'h80, 1'b1, 1'b0, 1'b0},
    '{8'hB4, 32'h0000_0011, 8'h11, 1'b0, 1'b1, 1'b1},
    '{8'hB4, 32'h8000_0022, 8'h22, 1'b0, 1'b1, 1'b0},
    '{8'hB8, 32'hFFFF_FFA5, 8'hA5, 1'b0, 1'b0, 1'b0},
    '{8'hB4, 32'h7F00_0033, 8'h33, 1'b0, 1'b1, 1'b1},
    '{8'hB4, 32'h0000_0144, 8'h44, 1'b0, 1'b1, 1'b1},
    '{8'hB4, 32'h8000_0055, 8'h55, 1'b0, 1'b1, 1'b0},
    '{8'hB0, 32'h0000_0030, 8'h30, 1'b1, 1'b0, 1'b0}
  };

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int w, w2, risesBefore, reBefore;
    logic [31:0] rd;
    string req;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    check(cmdLatch == 0 && addrLatch == 0, "R1", "latches idle", {cmdLatch, addrLatch}, 0);
    check(wrStrobeN && rdStrobeN, "R1", "strobes high", {wrStrobeN, rdStrobeN}, 3);
    check(chipEnN == 1 && wrProtN == 0, "R1", "ce/wp", {chipEnN, wrProtN}, 2);
    check(hostWait == 0, "R1", "wait idle", hostWait, 0);
    busRead(8'h00, rd); check(rd == 0, "R1", "global reg", rd, 0);
    busRead(8'hA0, rd); check(rd == 32'h0300_0000, "R1", "ctrl reg", rd, 32'h0300_0000);

    // R8 / R9 control fields
    busWrite(8'h00, 32'h0000_0008, w);
    busWrite(8'hA0, 32'h0000_003E, w);
    busRead(8'hA0, rd); check(rd == 32'h18, "R8", "ctrl readback", rd, 32'h18);
    check(wrProtN == 1, "R8", "wp released", wrProtN, 1);
    check(chipEnN == 0, "R9", "ce selected", chipEnN, 0);
    busWrite(8'hA0, 32'h0200_0000, w);
    check(chipEnN == 1, "R9", "ce deselected", chipEnN, 1);
    busWrite(8'hA0, 32'h0100_0000, w);
    check(wrProtN == 0 && chipEnN == 0, "R8", "wp set, ce low", {wrProtN, chipEnN}, 0);
    busWrite(8'hA0, 32'h0, w);

    // table of bus cycles (R2 command, R3 address, R4 data)
    for (int i = 0; i < NVEC; i++) begin
      req = (VECS[i].off == 8'hB0) ? "R2" : (VECS[i].off == 8'hB4) ? "R3" : "R4";
      risesBefore = weRises;
      busWrite(VECS[i].off, VECS[i].wdata, w);
      repeat (PULSE + 3) @(negedge clk);
      check(weRises == risesBefore + 1, req, "one write strobe", weRises - risesBefore, 1);
      check(weLen == PULSE, req, "strobe width", weLen, PULSE);
      check(lastIo == VECS[i].expByte, req, "byte after strobe", lastIo, VECS[i].expByte);
      check(lastCle == VECS[i].expCle && lastAle == VECS[i].expAle && lastOe, req, "cle/ale/oe",
            {lastCle, lastAle, lastOe}, {VECS[i].expCle, VECS[i].expAle, 1'b1});
      check(addrLatch == VECS[i].expAleAfter, req, "ale after cycle", addrLatch, VECS[i].expAleAfter);
    end

    // R5 data reads
    risesBefore = weRises; reBefore = reCount;
    ioIn = 8'h5C;
    busRead(8'hB8, rd);
    check(rd == 32'h5C, "R5", "read byte", rd, 32'h5C);
    check(reCount == reBefore + 1 && reLen == PULSE, "R5", "one read strobe", {reCount - reBefore, reLen}, {32'd1, PULSE});
    ioIn = 8'hA3;
    busRead(8'hB8, rd);
    check(rd == 32'hA3, "R5", "second read byte", rd, 32'hA3);
    check(weRises == risesBefore, "R5", "no write strobe", weRises - risesBefore, 0);

    // R6 back-to-back stall
    busWrite(8'hB0, 32'h70, w);
    busWrite(8'hB8, 32'h01, w2);
    check(w == 0, "R6", "idle write not stalled", w, 0);
    check(w2 == PULSE + 1, "R6", "stall length", w2, PULSE + 1);
    repeat (PULSE + 3) @(negedge clk);

    // R7 ready/busy synchroniser
    readyBusy = 0;
    repeat (3) @(negedge clk);
    hostSel = 1; hostWr = 0; hostAddr = 8'hAC; #1;
    check(hostRdata[18] == 0, "R7", "busy visible", hostRdata[18], 0);
    readyBusy = 1;
    @(negedge clk);
    check(hostRdata[18] == 0, "R7", "one edge later", hostRdata[18], 0);
    @(negedge clk);
    check(hostRdata[18] == 1, "R7", "two edges later", hostRdata[18], 1);
    hostSel = 0;
    @(negedge clk);

    // R10 soft reset closes address phase
    busWrite(8'hB4, 32'h66, w);
    repeat (PULSE + 3) @(negedge clk);
    check(addrLatch == 1, "R10", "phase open", addrLatch, 1);
    busWrite(8'hA0, 32'h0000_0001, w);
    check(addrLatch == 0, "R10", "phase closed", addrLatch, 0);
    busRead(8'hA0, rd); check(rd == 0, "R10", "reset bit reads 0", rd, 0);

    // R11 global interface reset
    busWrite(8'hB4, 32'h77, w);
    repeat (PULSE + 3) @(negedge clk);
    busWrite(8'h00, 32'h0000_0009, w);
    check(addrLatch == 0, "R11", "phase closed", addrLatch, 0);
    check(chipEnN == 1 && wrProtN == 0, "R11", "ce/wp defaults", {chipEnN, wrProtN}, 2);
    busRead(8'hA0, rd); check(rd == 32'h0300_0000, "R11", "ctrl restored", rd, 32'h0300_0000);
    busRead(8'h00, rd); check(rd == 32'h8, "R11", "enable kept", rd, 32'h8);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule